// File: doc/BRIEF.md
# FIFO DMA Request Generator

This block raises DMA transfer requests for the two data FIFOs of a streaming coprocessor. The input FIFO is filled by the DMA, and the output FIFO is drained by it. Each direction has two request lines, one for a burst and one for a single word. Each line has its own clear strobe, which the DMA controller drives back.

A burst is always four words. The block watches the occupancy count of each FIFO and compares it with that size. For the output FIFO it compares the words waiting to be read. For the input FIFO it compares the free slots, which are the depth minus the occupancy.

The two request lines of a direction are independent and can be high together. Once a request is raised, it holds until its clear arrives. It can rise again only after the clear has dropped, and only if its condition still holds. A global peripheral enable gates every request, and a per-direction DMA enable gates the requests of that direction.

Top module: `fifo_dma_req`

## Requirements
- R1: While `rst` is high at a rising edge, all four request outputs are 0 after that edge.
- R2: With both enables for the output side high and `out_burst_clr` low, `out_burst_req` is 1 one cycle after `out_fill` is at least 4.
- R3: Under the same gating, `out_single_req` is 1 one cycle after `out_fill` is at least 1, whether or not `out_burst_req` is also high. With 6 words ready, both requests are high; after the burst is cleared and 2 words remain, only the single request rises again.
- R4: With both enables for the input side high and `in_burst_clr` low, `in_burst_req` is 1 one cycle after `DEPTH - in_fill` is at least 4.
- R5: Under the same gating, `in_single_req` is 1 one cycle after `DEPTH - in_fill` is at least 1.
- R6: A request that is high stays high, even if its occupancy condition no longer holds, until its clear is sampled high or its gating drops.
- R7: While a clear input is high at a rising edge, its request is 0 after that edge. In the first cycle with the clear low, the request is re-evaluated from the occupancy condition.
- R8: While `periph_en` is low at a rising edge, all four requests are 0 after that edge.
- R9: While `in_dma_en` is low, both input-side requests are forced to 0. The output-side requests are unaffected.
- R10: While `out_dma_en` is low, both output-side requests are forced to 0. The input-side requests are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_en | input | 1 | Global peripheral enable |
| in_dma_en | input | 1 | DMA enable for the input FIFO |
| out_dma_en | input | 1 | DMA enable for the output FIFO |
| in_fill | input | $clog2(DEPTH+1) | Words held in the input FIFO |
| out_fill | input | $clog2(DEPTH+1) | Words held in the output FIFO |
| in_burst_clr | input | 1 | DMA clear for the input burst request |
| in_single_clr | input | 1 | DMA clear for the input single request |
| out_burst_clr | input | 1 | DMA clear for the output burst request |
| out_single_clr | input | 1 | DMA clear for the output single request |
| in_burst_req | output | 1 | Input burst request (at least 4 free slots) |
| in_single_req | output | 1 | Input single request (at least 1 free slot) |
| out_burst_req | output | 1 | Output burst request (at least 4 words ready) |
| out_single_req | output | 1 | Output single request (at least 1 word ready) |

## Verification
Random fill levels across the full 0 to DEPTH range cover the threshold points at 0, 1, 3, 4 and DEPTH. Those points separate a burst threshold from a single threshold, and they show whether the input side counts free slots or used slots.

Clears arrive at random about a quarter of the time, so the stimulus often lowers a condition while a request is held. That tells a sticky request apart from a purely combinational one. Rare drops of each enable show whether the gating is global or confined to one direction.

Directed sequences replay the six-word burst-then-single case. They also hold a clear high across several cycles, to show that a request cannot re-arm until the clear falls.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  // Words that the DMA may move for one direction.
  // For the input FIFO that is free space; for the output FIFO it is stored data.
  function automatic int unsigned movable_words(int unsigned fill,
                                                int unsigned depth,
                                                bit          is_input);
    if (is_input) return (fill > depth) ? 0 : depth - fill;
    return fill;
  endfunction

  // Threshold test shared by burst and single requests.
  function automatic logic enough(int unsigned avail, int unsigned need);
    return avail >= need;
  endfunction

  // Next state of a sticky request register.
  function automatic logic req_next(logic cur, logic gate, logic clr, logic cond);
    return gate & ~clr & (cur | cond);
  endfunction

endpackage

// File: rtl/dma_req_cell.sv
module dma_req_cell (
  input  logic clk,
  input  logic rst,
  input  logic gate,
  input  logic cond,
  input  logic clr,
  output logic req
);
  import dma_req_pkg::*;

  logic req_q;

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= req_next(req_q, gate, clr, cond);
  end

  assign req = req_q;

  AST_CLR_DROPS:   assert property (@(posedge clk) disable iff (rst) clr |=> !req);                  // R7
  AST_GATE_DROPS:  assert property (@(posedge clk) disable iff (rst) !gate |=> !req);                // R8
  AST_HOLD:        assert property (@(posedge clk) disable iff (rst) (req && gate && !clr) |=> req); // R6
  AST_RISE_CAUSE:  assert property (@(posedge clk) disable iff (rst) $rose(req) |-> $past(cond));     // R2
endmodule

// File: rtl/dma_req_chan.sv
module dma_req_chan #(
  parameter int DEPTH       = 8,
  parameter int BURST_WORDS = 4,
  parameter bit IS_INPUT    = 1'b0,
  localparam int CW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gate,
  input  logic [CW-1:0] fill,
  input  logic          burst_clr,
  input  logic          single_clr,
  output logic          burst_req,
  output logic          single_req
);
  import dma_req_pkg::*;

  // Named events for the checks below.
  logic burst_ok;
  logic single_ok;
  int unsigned avail;

  always_comb begin
    avail     = movable_words(32'(fill), DEPTH, IS_INPUT);
    burst_ok  = enough(avail, BURST_WORDS);
    single_ok = enough(avail, 1);
  end

  dma_req_cell u_burst (
    .clk (clk), .rst (rst), .gate (gate), .cond (burst_ok),
    .clr (burst_clr), .req (burst_req)
  );

  dma_req_cell u_single (
    .clk (clk), .rst (rst), .gate (gate), .cond (single_ok),
    .clr (single_clr), .req (single_req)
  );

  generate
    if (IS_INPUT) begin : g_in_chk
      AST_IN_BURST_ROOM: assert property (@(posedge clk) disable iff (rst)
        (gate && !burst_clr && (DEPTH - int'(fill) >= BURST_WORDS)) |=> burst_req); // R4
      AST_IN_SINGLE_ROOM: assert property (@(posedge clk) disable iff (rst)
        (gate && !single_clr && (int'(fill) < DEPTH)) |=> single_req);              // R5
    end else begin : g_out_chk
      AST_OUT_BURST_DATA: assert property (@(posedge clk) disable iff (rst)
        (gate && !burst_clr && (int'(fill) >= BURST_WORDS)) |=> burst_req);         // R2
      AST_OUT_SINGLE_DATA: assert property (@(posedge clk) disable iff (rst)
        (gate && !single_clr && (fill != '0)) |=> single_req);                      // R3
    end
  endgenerate
endmodule

// File: rtl/fifo_dma_req.sv
module fifo_dma_req #(
  parameter int DEPTH       = 8,
  parameter int BURST_WORDS = 4,
  localparam int CW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          periph_en,
  input  logic          in_dma_en,
  input  logic          out_dma_en,
  input  logic [CW-1:0] in_fill,
  input  logic [CW-1:0] out_fill,
  input  logic          in_burst_clr,
  input  logic          in_single_clr,
  input  logic          out_burst_clr,
  input  logic          out_single_clr,
  output logic          in_burst_req,
  output logic          in_single_req,
  output logic          out_burst_req,
  output logic          out_single_req
);
  logic in_gate;
  logic out_gate;

  assign in_gate  = periph_en & in_dma_en;
  assign out_gate = periph_en & out_dma_en;

  dma_req_chan #(.DEPTH(DEPTH), .BURST_WORDS(BURST_WORDS), .IS_INPUT(1'b1)) u_in (
    .clk (clk), .rst (rst), .gate (in_gate), .fill (in_fill),
    .burst_clr (in_burst_clr), .single_clr (in_single_clr),
    .burst_req (in_burst_req), .single_req (in_single_req)
  );

  dma_req_chan #(.DEPTH(DEPTH), .BURST_WORDS(BURST_WORDS), .IS_INPUT(1'b0)) u_out (
    .clk (clk), .rst (rst), .gate (out_gate), .fill (out_fill),
    .burst_clr (out_burst_clr), .single_clr (out_single_clr),
    .burst_req (out_burst_req), .single_req (out_single_req)
  );

  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> !(in_burst_req || in_single_req || out_burst_req || out_single_req));           // R1
  AST_IN_GATED: assert property (@(posedge clk) disable iff (rst)
    !in_dma_en |=> !(in_burst_req || in_single_req));                                     // R9
  AST_OUT_GATED: assert property (@(posedge clk) disable iff (rst)
    !out_dma_en |=> !(out_burst_req || out_single_req));                                  // R10
endmodule

// File: tb/tb_fifo_dma_req.sv
module tb_fifo_dma_req;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic periph_en = 1'b0, in_dma_en = 1'b0, out_dma_en = 1'b0;
  logic [CW-1:0] in_fill = '0, out_fill = '0;
  logic in_burst_clr = 1'b0, in_single_clr = 1'b0, out_burst_clr = 1'b0, out_single_clr = 1'b0;
  logic in_burst_req, in_single_req, out_burst_req, out_single_req;

  int checks = 0;
  int fails  = 0;
  logic [3:0] exp_q = '0;  // {ib, is, ob, os}

  always #5 clk = ~clk;

  fifo_dma_req #(.DEPTH(DEPTH)) dut (.*);

  function automatic logic sticky(logic cur, logic en, logic clr, logic hit);
    if (!en || clr) return 1'b0;
    return cur ? 1'b1 : hit;
  endfunction

  function automatic logic [3:0] model_step(logic [3:0] cur);
    logic [3:0] n;
    int room;
    if (rst) return 4'b0;
    room = DEPTH - int'(in_fill);
    n[3] = sticky(cur[3], periph_en & in_dma_en,  in_burst_clr,   room >= 4);
    n[2] = sticky(cur[2], periph_en & in_dma_en,  in_single_clr,  room >= 1);
    n[1] = sticky(cur[1], periph_en & out_dma_en, out_burst_clr,  int'(out_fill) >= 4);
    n[0] = sticky(cur[0], periph_en & out_dma_en, out_single_clr, int'(out_fill) >= 1);
    return n;
  endfunction

  task automatic check1(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // Compare at the falling edge, then advance the model over the coming rising edge.
  task automatic compare(string note);
    check1(in_burst_req,   exp_q[3], {note, " in_burst R4/R6/R7/R8/R9"});
    check1(in_single_req,  exp_q[2], {note, " in_single R5/R6/R7/R8/R9"});
    check1(out_burst_req,  exp_q[1], {note, " out_burst R2/R6/R7/R8/R10"});
    check1(out_single_req, exp_q[0], {note, " out_single R3/R6/R7/R8/R10"});
  endtask

  task automatic tick(string note);
    exp_q = model_step(exp_q);
    @(negedge clk);
    compare(note);
  endtask

  task automatic set_in(logic pe, logic ie, logic oe, int inf, int outf, logic [3:0] clrs);
    periph_en = pe; in_dma_en = ie; out_dma_en = oe;
    in_fill = CW'(inf); out_fill = CW'(outf);
    {in_burst_clr, in_single_clr, out_burst_clr, out_single_clr} = clrs;
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    rst = 1'b1;
    set_in(1, 1, 1, 0, 8, 4'b0);
    tick("R1 reset");
    tick("R1 reset");
    rst = 1'b0;

    // R3 six words ready: both output requests, then single only after the burst clear
    set_in(1, 1, 1, 8, 6, 4'b0);
    tick("R3 six-ready");
    check1(out_burst_req & out_single_req, 1'b1, "R3 both high with 6");
    set_in(1, 1, 1, 8, 2, 4'b0010);
    tick("R3 burst clear");
    set_in(1, 1, 1, 8, 2, 4'b0000);
    tick("R3 after burst");
    check1(out_burst_req, 1'b0, "R3 burst stays low with 2");
    check1(out_single_req, 1'b1, "R3 single holds for 2");

    // R6 held though condition gone
    set_in(1, 1, 1, 8, 0, 4'b0);
    tick("R6 hold");
    check1(out_single_req, 1'b1, "R6 single held at 0 words");

    // R7 clear held across cycles blocks re-arm
    set_in(1, 1, 1, 0, 8, 4'b1111);
    for (int k = 0; k < 3; k++) tick("R7 clear held");
    set_in(1, 1, 1, 0, 8, 4'b0000);
    tick("R7 after release");
    check1(in_burst_req & out_burst_req, 1'b1, "R7 re-armed after clear falls");

    // R9/R10 per-direction gating, R8 global gating
    set_in(1, 0, 1, 0, 8, 4'b0);
    tick("R9 in off");
    check1(out_burst_req, 1'b1, "R9 output untouched");
    set_in(1, 1, 0, 0, 8, 4'b0);
    tick("R10 out off");
    check1(in_single_req, 1'b1, "R10 input untouched");
    set_in(0, 1, 1, 0, 8, 4'b0);
    tick("R8 periph off");

    // R4/R5 input thresholds: 4 free vs 3 free vs full
    set_in(1, 1, 1, 4, 0, 4'b0);
    tick("R4 four free");
    set_in(1, 1, 1, 5, 0, 4'b1111);
    tick("R4 clear");
    set_in(1, 1, 1, 5, 0, 4'b0);
    tick("R4 three free");
    set_in(1, 1, 1, 8, 0, 4'b1111);
    tick("R5 clear");
    set_in(1, 1, 1, 8, 0, 4'b0);
    tick("R5 full");

    // Constrained random
    for (int i = 0; i < 3000; i++) begin
      set_in(($urandom % 20) != 0, ($urandom % 12) != 0, ($urandom % 12) != 0,
             int'($urandom % (DEPTH + 1)), int'($urandom % (DEPTH + 1)),
             {($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0});
      rst = (($urandom % 500) == 0);
      tick(rst ? "R1 random" : "random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule